// File: doc/BRIEF.md
# BAR Window Decoder

This block holds the address windows of a device's base address registers: several general regions plus one expansion ROM region. On a remap pulse it takes the stored BAR values, the region sizes and the command enable bits. From these it works out which regions currently form a valid window, and it stores the result in a registered table.

Incoming I/O or memory lookups are then compared against that table in a single cycle. The block returns a hit flag and the index of the winning region. Regions that are disabled or invalid stay unmapped and never match. A per-region event pulse reports every change of a region's mapped base, including a region becoming mapped or unmapped.

The general regions take indices 0 to N_BARS-1. The ROM region takes index N_BARS.

Top module: `bar_window_decoder`

## Requirements
- R1: A region of size S (a power of two) with BAR value V covers base = V & ~(S-1) through base + S - 1. Addresses inside that range hit the region. Addresses one past the end miss it.
- R2: A region whose size is 0 is never mapped and never hits.
- R3: An I/O region is mapped only while `cmd_io_en` was set at the remap. It is rejected if its base is 0 or if its end is 0x10000 or higher.
- R4: A memory region is mapped only while `cmd_mem_en` was set at the remap. It is rejected if its base is 0 or if its end is 0xFFFFFFFF.
- R5: A window whose end is not above its base is rejected. With an aligned power-of-two window this is the size-1 case.
- R6: The ROM region (index N_BARS) is always memory type. It is mapped only if bit 0 of its BAR value is 1.
- R7: For a general region, bit 0 of the BAR value selects the type: 1 means I/O, 0 means memory. An I/O lookup (`lk_is_io`=1) matches only I/O regions, and a memory lookup matches only memory regions.
- R8: When several mapped regions contain the address, the lowest index is reported.
- R9: The window table changes only at a clock edge where `remap_req` is 1. BAR, size or enable changes without a remap leave lookup results unchanged.
- R10: In the cycle after a remap, `map_event[i]` is 1 exactly when region i changed between mapped and unmapped, or stayed mapped with a different base. At all other times `map_event` is 0.
- R11: `hit` and `hit_region` are registered. They give the result of the lookup sampled at the previous edge. With no lookup, or on a miss, both are 0.
- R12: After reset all regions are unmapped, and `hit`, `hit_region` and `map_event` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remap_req | input | 1 | Pulse: rebuild the window table from the current inputs |
| cmd_io_en | input | 1 | Command I/O space enable |
| cmd_mem_en | input | 1 | Command memory space enable |
| bar_value | input | (N_BARS+1)*32 | BAR values, region i at bits [32*i +: 32], ROM last |
| region_size | input | (N_BARS+1)*32 | Region sizes in bytes (power of two or 0), same packing |
| lk_valid | input | 1 | Lookup request |
| lk_is_io | input | 1 | Lookup is in I/O space (1) or memory space (0) |
| lk_addr | input | 32 | Lookup address |
| hit | output | 1 | Registered: the previous lookup hit a mapped window |
| hit_region | output | $clog2(N_BARS+1) | Registered: index of the winning region, 0 on miss |
| map_event | output | N_BARS+1 | One-cycle pulse per region whose mapped base changed |

## Verification
The assertions take for granted that every region size is zero or a power of two, and that a remap is a level sampled at a clock edge. They also assume the enable state they track only changes the table through a remap. The directed stimulus uses sizes from a small hand-picked set. The random phase builds every size as zero or a single shifted one bit, so the power-of-two assumption always holds. Lookups are driven on the falling edge and held for one full cycle, so each sampled request is well defined.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int AW            = 32;
    localparam int IO_SPAN_BITS  = 16;

    typedef struct packed {
        logic          live;
        logic          is_io;
        logic [AW-1:0] base;
        logic [AW-1:0] mask;
    } window_t;

    // Derive one region's window from its BAR, size and the enables.
    function automatic window_t calc_window(
        input logic [AW-1:0] bar,
        input logic [AW-1:0] size,
        input logic          is_rom,
        input logic          io_en,
        input logic          mem_en
    );
        window_t       w;
        logic [AW-1:0] msk;
        logic [AW-1:0] bse;
        logic [AW-1:0] last;
        logic          ok;
        msk     = size - AW'(1);
        bse     = bar & ~msk;
        last    = bse + msk;
        w.is_io = !is_rom && bar[0];
        if (w.is_io) begin
            ok = io_en && ((last >> IO_SPAN_BITS) == '0);
        end else begin
            ok = mem_en && (!is_rom || bar[0]) && (last != '1);
        end
        ok     = ok && (size != '0) && (bse != '0) && (last > bse);
        w.live = ok;
        w.base = ok ? bse : '0;
        w.mask = msk;
        return w;
    endfunction

endpackage

// File: rtl/bwd_window_calc.sv
module bwd_window_calc
    import bwd_pkg::*;
#(
    parameter int NREG    = 7,
    parameter int ROM_IDX = 6
) (
    input  logic [NREG*AW-1:0] bar_value,
    input  logic [NREG*AW-1:0] region_size,
    input  logic               cmd_io_en,
    input  logic               cmd_mem_en,
    output window_t [NREG-1:0] next_win
);

    for (genvar gi = 0; gi < NREG; gi++) begin : g_region
        localparam logic IS_ROM = (gi == ROM_IDX);
        assign next_win[gi] = calc_window(bar_value[gi*AW +: AW],
                                          region_size[gi*AW +: AW],
                                          IS_ROM, cmd_io_en, cmd_mem_en);
    end

endmodule

// File: rtl/bwd_window_table.sv
module bwd_window_table
    import bwd_pkg::*;
#(
    parameter int NREG = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               remap_req,
    input  window_t [NREG-1:0] next_win,
    output window_t [NREG-1:0] win,
    output logic [NREG-1:0]    map_event
);

    logic [NREG-1:0] differs;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_diff
        assign differs[gi] = (win[gi].live != next_win[gi].live) ||
                             (next_win[gi].live && (win[gi].base != next_win[gi].base));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win       <= '0;
            map_event <= '0;
        end else begin
            map_event <= remap_req ? differs : '0;
            if (remap_req) begin
                win <= next_win;
            end
        end
    end

endmodule

// File: rtl/bwd_priority_match.sv
module bwd_priority_match
    import bwd_pkg::*;
#(
    parameter int NREG  = 7,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  window_t [NREG-1:0] win,
    input  logic               lk_valid,
    input  logic               lk_is_io,
    input  logic [AW-1:0]      lk_addr,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_region
);

    logic [NREG-1:0] cand;
    logic [IDX_W-1:0] sel;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_cmp
        assign cand[gi] = win[gi].live && (win[gi].is_io == lk_is_io) &&
                          ((lk_addr & ~win[gi].mask) == win[gi].base);
    end

    // Scan downward so the lowest matching index is the last assignment.
    always_comb begin
        sel = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (cand[i]) sel = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !lk_valid) begin
            hit        <= 1'b0;
            hit_region <= '0;
        end else begin
            hit        <= |cand;
            hit_region <= (|cand) ? sel : '0;
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bwd_pkg::*;
#(
    parameter int  N_BARS = 6,
    localparam int NREG   = N_BARS + 1,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               remap_req,
    input  logic               cmd_io_en,
    input  logic               cmd_mem_en,
    input  logic [NREG*AW-1:0] bar_value,
    input  logic [NREG*AW-1:0] region_size,
    input  logic               lk_valid,
    input  logic               lk_is_io,
    input  logic [AW-1:0]      lk_addr,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_region,
    output logic [NREG-1:0]    map_event
);

    window_t [NREG-1:0] next_win;
    window_t [NREG-1:0] win;

    bwd_window_calc #(.NREG(NREG), .ROM_IDX(N_BARS)) calc_i (
        .bar_value   (bar_value),
        .region_size (region_size),
        .cmd_io_en   (cmd_io_en),
        .cmd_mem_en  (cmd_mem_en),
        .next_win    (next_win)
    );

    bwd_window_table #(.NREG(NREG)) table_i (
        .clk       (clk),
        .rst       (rst),
        .remap_req (remap_req),
        .next_win  (next_win),
        .win       (win),
        .map_event (map_event)
    );

    bwd_priority_match #(.NREG(NREG), .IDX_W(IDX_W)) match_i (
        .clk        (clk),
        .rst        (rst),
        .win        (win),
        .lk_valid   (lk_valid),
        .lk_is_io   (lk_is_io),
        .lk_addr    (lk_addr),
        .hit        (hit),
        .hit_region (hit_region)
    );

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
    parameter int  N_BARS = 6,
    localparam int NREG   = N_BARS + 1,
    localparam int IDX_W  = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst,
    input logic             remap_req,
    input logic             cmd_io_en,
    input logic             cmd_mem_en,
    input logic             rom_enable,
    input logic             lk_valid,
    input logic             lk_is_io,
    input logic             hit,
    input logic [IDX_W-1:0] hit_region,
    input logic [NREG-1:0]  map_event
);

    // Track the enables that were captured by the last remap.
    logic io_off, mem_off, rom_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_off  <= 1'b0;
            mem_off <= 1'b0;
            rom_off <= 1'b0;
        end else if (remap_req) begin
            io_off  <= !cmd_io_en;
            mem_off <= !cmd_mem_en;
            rom_off <= !rom_enable;
        end
    end

    p_region_bound_r8: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(hit_region) <= N_BARS));

    p_idle_no_hit_r11: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!hit && hit_region == '0));

    p_event_needs_remap_r10: assert property (@(posedge clk) disable iff (rst)
        !remap_req |=> (map_event == '0));

    p_io_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (io_off && lk_valid && lk_is_io) |=> !hit);

    p_mem_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_off && lk_valid && !lk_is_io) |=> !hit);

    p_rom_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (rom_off && lk_valid) |=> !(hit && int'(hit_region) == N_BARS));

endmodule

bind bar_window_decoder bwd_checker #(.N_BARS(N_BARS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .remap_req  (remap_req),
    .cmd_io_en  (cmd_io_en),
    .cmd_mem_en (cmd_mem_en),
    .rom_enable (bar_value[N_BARS*32]),
    .lk_valid   (lk_valid),
    .lk_is_io   (lk_is_io),
    .hit        (hit),
    .hit_region (hit_region),
    .map_event  (map_event)
);

// File: tb/bar_window_decoder_tb_top.sv
`timescale 1ns/1ps
module bar_window_decoder_tb_top;

    localparam int N_BARS = 6;
    localparam int NREG   = N_BARS + 1;
    localparam int IDX_W  = $clog2(NREG);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               remap_req = 1'b0;
    logic               cmd_io_en = 1'b0;
    logic               cmd_mem_en = 1'b0;
    logic [NREG*32-1:0] bar_value = '0;
    logic [NREG*32-1:0] region_size = '0;
    logic               lk_valid = 1'b0;
    logic               lk_is_io = 1'b0;
    logic [31:0]        lk_addr = '0;
    logic               hit;
    logic [IDX_W-1:0]   hit_region;
    logic [NREG-1:0]    map_event;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    bar_window_decoder #(.N_BARS(N_BARS)) dut_i (.*);

    // ---------------- behavioural reference model ----------------
    bit     m_live [NREG];
    bit     m_io   [NREG];
    longint m_base [NREG];
    longint m_end  [NREG];
    bit              e_hit;
    int              e_idx;
    logic [NREG-1:0] e_evt;

    task automatic region_rule(input int i, output bit live, output bit io,
                               output longint b, output longint e);
        longint bar, sz;
        bar  = longint'({32'b0, bar_value[i*32 +: 32]});
        sz   = longint'({32'b0, region_size[i*32 +: 32]});
        io   = (i != N_BARS) && (bar % 2 == 1);
        live = 0; b = 0; e = 0;
        if (sz != 0) begin
            b = bar - (bar % sz);
            e = b + sz - 1;
            if (io) live = cmd_io_en && b != 0 && e > b && e < 65536;
            else    live = cmd_mem_en && (i != N_BARS || bar % 2 == 1) &&
                           b != 0 && e > b && e != 64'hFFFF_FFFF;
        end
        if (!live) begin b = 0; e = 0; end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                m_live[i] = 0; m_io[i] = 0; m_base[i] = 0; m_end[i] = 0;
            end
            e_hit = 0; e_idx = 0; e_evt = '0;
        end else begin
            e_hit = 0; e_idx = 0;
            if (lk_valid) begin
                for (int i = 0; i < NREG; i++) begin
                    if (!e_hit && m_live[i] && m_io[i] == lk_is_io &&
                        longint'({32'b0, lk_addr}) >= m_base[i] &&
                        longint'({32'b0, lk_addr}) <= m_end[i]) begin
                        e_hit = 1; e_idx = i;
                    end
                end
            end
            e_evt = '0;
            if (remap_req) begin
                for (int i = 0; i < NREG; i++) begin
                    bit nl, nio; longint nb, ne;
                    region_rule(i, nl, nio, nb, ne);
                    e_evt[i] = (nl != m_live[i]) || (nl && nb != m_base[i]);
                    m_live[i] = nl; m_io[i] = nio; m_base[i] = nb; m_end[i] = ne;
                end
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if (hit !== e_hit || int'(hit_region) != e_idx || map_event !== e_evt) begin
                n_errors++;
                $display("FAIL model R8 R10 R11: got hit=%0b idx=%0d evt=%b, expected hit=%0b idx=%0d evt=%b",
                         hit, hit_region, map_event, e_hit, e_idx, e_evt);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic set_region(input int i, input logic [31:0] v, input logic [31:0] s);
        bar_value[i*32 +: 32]   = v;
        region_size[i*32 +: 32] = s;
    endtask

    task automatic check(input string tag, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_remap(input logic [NREG-1:0] exp_evt, input string tag);
        @(negedge clk); remap_req = 1'b1;
        @(negedge clk); remap_req = 1'b0;
        check(tag, longint'(map_event), longint'(exp_evt));
    endtask

    task automatic do_lookup(input logic io, input logic [31:0] a,
                             input bit exp_hit, input int exp_idx, input string tag);
        @(negedge clk); lk_valid = 1'b1; lk_is_io = io; lk_addr = a;
        @(negedge clk); lk_valid = 1'b0;
        check({tag, " hit"}, longint'(hit), longint'(exp_hit));
        check({tag, " region"}, longint'(hit_region), longint'(exp_hit ? exp_idx : 0));
    endtask

    // ---------------- stimulus ----------------
    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 hit after reset", longint'(hit), 0);
        check("R12 event after reset", longint'(map_event), 0);
        do_lookup(1'b0, 32'h0000_0000, 0, 0, "R12 table empty");

        set_region(0, 32'h4000_0000, 32'h0000_1000);
        set_region(1, 32'h0000_1001, 32'h0000_0100);
        set_region(2, 32'h4000_0000, 32'h0001_0000);
        set_region(3, 32'h7000_0000, 32'h0000_0000);
        set_region(4, 32'h5000_0000, 32'h0000_0001);
        set_region(5, 32'h0001_0001, 32'h0000_0200);
        set_region(6, 32'h6000_0001, 32'h0000_0800);
        cmd_io_en = 1'b1; cmd_mem_en = 1'b1;
        do_remap(7'b100_0111, "R10 first map");

        do_lookup(1'b0, 32'h4000_0FFC, 1, 0, "R8 overlap low index");
        do_lookup(1'b0, 32'h4000_1000, 1, 2, "R1 past small window");
        do_lookup(1'b0, 32'h4001_0000, 0, 0, "R1 past end");
        do_lookup(1'b1, 32'h0000_10FF, 1, 1, "R1 io last byte");
        do_lookup(1'b1, 32'h0000_1100, 0, 0, "R1 io past end");
        do_lookup(1'b1, 32'h4000_0000, 0, 0, "R7 io lookup on memory");
        do_lookup(1'b0, 32'h0000_1000, 0, 0, "R7 memory lookup on io");
        do_lookup(1'b0, 32'h5000_0000, 0, 0, "R5 size one");
        do_lookup(1'b1, 32'h0001_0000, 0, 0, "R3 io above 64K");
        do_lookup(1'b0, 32'h6000_07FF, 1, 6, "R6 rom enabled");
        do_lookup(1'b0, 32'h7000_0000, 0, 0, "R2 zero size");

        set_region(0, 32'h4800_0000, 32'h0000_1000);
        do_lookup(1'b0, 32'h4800_0000, 0, 0, "R9 no remap new base");
        do_lookup(1'b0, 32'h4000_0000, 1, 0, "R9 no remap old base");
        do_remap(7'b000_0001, "R10 moved base");
        do_lookup(1'b0, 32'h4800_0000, 1, 0, "R9 after remap");
        do_remap(7'b000_0000, "R10 no change");

        cmd_io_en = 1'b0;
        do_remap(7'b000_0010, "R10 io disable");
        do_lookup(1'b1, 32'h0000_1000, 0, 0, "R3 io disabled");

        set_region(6, 32'h6000_0000, 32'h0000_0800);
        do_remap(7'b100_0000, "R6 rom enable cleared");
        do_lookup(1'b0, 32'h6000_0000, 0, 0, "R6 rom off");

        cmd_mem_en = 1'b0;
        do_remap(7'b000_0101, "R4 memory disable");
        do_lookup(1'b0, 32'h4800_0000, 0, 0, "R4 memory disabled");

        cmd_mem_en = 1'b1; cmd_io_en = 1'b1;
        set_region(0, 32'h0000_0FFF, 32'h0000_1000);
        set_region(2, 32'hFFFF_0000, 32'h0001_0000);
        set_region(1, 32'h0000_0001, 32'h0000_0100);
        do_remap(7'b000_0000, "R4 base zero and top end");
        do_lookup(1'b0, 32'hFFFF_0000, 0, 0, "R4 end all ones");
        do_lookup(1'b0, 32'h0000_0010, 0, 0, "R4 base zero");
        do_lookup(1'b1, 32'h0000_0010, 0, 0, "R3 io base zero");

        // Random phase, checked by the reference model every clock.
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            remap_req = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 3) == 0) begin
                int r, k;
                logic [31:0] v;
                r = $urandom_range(0, NREG - 1);
                k = $urandom_range(0, 20);
                v = $urandom;
                if ($urandom_range(0, 1) == 1) v = (v & 32'h0001_FFFF) | 32'h1;
                set_region(r, v, (k == 0) ? 32'h0 : (32'h1 << (k - 1)));
            end
            if ($urandom_range(0, 15) == 0) cmd_io_en  = ~cmd_io_en;
            if ($urandom_range(0, 15) == 0) cmd_mem_en = ~cmd_mem_en;
            lk_valid = ($urandom_range(0, 3) != 0);
            begin
                int r;
                r = $urandom_range(0, NREG - 1);
                lk_addr  = bar_value[r*32 +: 32] ^ ($urandom & 32'h0000_03FF);
                lk_is_io = (r != N_BARS) && bar_value[r*32] && ($urandom_range(0, 4) != 0);
            end
        end
        @(negedge clk); remap_req = 1'b0; lk_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog R11: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule